// File: doc/BRIEF.md
# Two-Phase Clock Sequence Checker

This block watches a pair of non-overlapping phase clocks and a reset line that belongs to the logic those clocks drive. It samples all three with a faster free-running clock and reports any sample stream that breaks the phase ordering or the reset release rule. It can run in simulation or in an FPGA debug harness, next to the logic that consumes the phase clocks.

Each sample of the two phases falls into one of four classes: phase A only, phase B only, both low, or both high. A region tracker expects a repeating loop. A run of A-only samples comes first, then an optional run of both-low samples, then a run of B-only samples, then another optional run of both-low samples, and then A again. The tracker stays unsynchronised until it sees the first A-only sample. A second tracker follows the monitored reset. After the reset is released, it must stay low across a fixed number of phase-A rising edges. It must then be high at the next phase-B rising edge.

A violation raises a one-cycle pulse and sets a bit in a sticky error code. It also sets a sticky summary flag. The sticky state clears only through the checker clear input or the checker reset.

Top module: `phase_seq_monitor`

## Requirements
- R1: A sample with ph_a and ph_b both high is an overlap violation in any tracker state, armed or not. It sets err_code bit 0, and after it the region tracker returns to the unsynchronised state.
- R2: While unsynchronised (after checker reset or after an overlap), B-only and both-low samples raise no ordering violation. The tracker arms on the first A-only sample.
- R3: Once armed, a stream that loops through A-only (1 or more samples), both-low (0 or more), B-only (1 or more) and both-low (0 or more), back to A-only, raises no violation.
- R4: Once armed, an A-only sample that follows the both-low run after an A-only region, with no B-only region between them, sets err_code bit 1.
- R5: Once armed, a B-only sample that follows the both-low run after a B-only region, with no A-only region between them, sets err_code bit 1.
- R6: After sys_rst falls, sys_rst must stay low until NUM_C1_EDGES rising edges of ph_a have been seen. A sample with sys_rst high before then sets err_code bit 2.
- R7: After those NUM_C1_EDGES ph_a rising edges, sys_rst must be high in the sample where ph_b next rises. If it is low there, err_code bit 2 is set; if it is high, nothing is flagged.
- R8: viol_pulse is high in the cycle after a sample with at least one violation, and low in the cycle after a sample with none.
- R9: err_code bits and err_sticky stay set until a sample with clr high. That sample clears them, except for any bits set by a violation in that same sample. err_sticky is high exactly when err_code is nonzero.
- R10: While the synchronous checker reset rst is high, all outputs are zero and both trackers return to their idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| rst | input | 1 | Synchronous active-high checker reset |
| clr | input | 1 | Clears the sticky error state |
| ph_a | input | 1 | First phase clock (sampled as data) |
| ph_b | input | 1 | Second phase clock (sampled as data) |
| sys_rst | input | 1 | Monitored reset of the phase-clocked logic |
| err_sticky | output | 1 | High while any error code bit is set |
| err_code | output | 3 | Sticky bits: 0 overlap, 1 ordering, 2 reset rule |
| viol_pulse | output | 1 | One-cycle pulse for each violating sample |

## Verification
The bench builds the checker with NUM_C1_EDGES at its default of 3. At that value, a release sequence with three full phase loops can be driven in a few dozen samples. Those sequences reach both the early-reassertion failure and the level check at the following B rise. Random region lengths, including zero-length gaps, run the loop through every legal transition. Directed samples then hit each illegal transition and the clear-versus-new-violation overlap.

// File: rtl/phase_mon_pkg.sv
package phase_mon_pkg;

    typedef enum logic [1:0] {
        SK_GAP  = 2'b00,
        SK_A    = 2'b01,
        SK_B    = 2'b10,
        SK_BOTH = 2'b11
    } sample_kind_e;

    typedef enum logic [2:0] {
        PH_UNSYNC,
        PH_A_RUN,
        PH_GAP_AFTER_A,
        PH_B_RUN,
        PH_GAP_AFTER_B
    } phase_state_e;

    typedef enum logic [1:0] {
        RR_IDLE,
        RR_COUNT,
        RR_WAIT_B
    } rel_state_e;

    localparam int ERR_W   = 3;
    localparam int ERR_OVL = 0;
    localparam int ERR_ORD = 1;
    localparam int ERR_RST = 2;

    function automatic sample_kind_e classify(input logic a, input logic b);
        return sample_kind_e'({b, a});
    endfunction

endpackage

// File: rtl/phase_order_fsm.sv
module phase_order_fsm
    import phase_mon_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  sample_kind_e kind,
    output logic         ovl_err,
    output logic         ord_err
);

    phase_state_e state, nxt;

    always_comb begin
        nxt     = state;
        ord_err = 1'b0;
        ovl_err = (kind == SK_BOTH);
        if (ovl_err) begin
            nxt = PH_UNSYNC;
        end else begin
            case (state)
                PH_UNSYNC: begin
                    if (kind == SK_A) nxt = PH_A_RUN;
                end
                PH_A_RUN: begin
                    if (kind == SK_GAP)    nxt = PH_GAP_AFTER_A;
                    else if (kind == SK_B) nxt = PH_B_RUN;
                end
                PH_GAP_AFTER_A: begin
                    if (kind == SK_B) begin
                        nxt = PH_B_RUN;
                    end else if (kind == SK_A) begin
                        ord_err = 1'b1;
                        nxt     = PH_A_RUN;
                    end
                end
                PH_B_RUN: begin
                    if (kind == SK_GAP)    nxt = PH_GAP_AFTER_B;
                    else if (kind == SK_A) nxt = PH_A_RUN;
                end
                PH_GAP_AFTER_B: begin
                    if (kind == SK_A) begin
                        nxt = PH_A_RUN;
                    end else if (kind == SK_B) begin
                        ord_err = 1'b1;
                        nxt     = PH_B_RUN;
                    end
                end
                default: nxt = PH_UNSYNC;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PH_UNSYNC;
        else     state <= nxt;
    end

    // R3
    gap_a_not_to_gap_b_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PH_GAP_AFTER_A) |=> (state != PH_GAP_AFTER_B));

    // R3
    gap_b_not_to_gap_a_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PH_GAP_AFTER_B) |=> (state != PH_GAP_AFTER_A));

    // R2
    unsync_no_order_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PH_UNSYNC) |-> !ord_err);

endmodule

// File: rtl/reset_rule_tracker.sv
module reset_rule_tracker
    import phase_mon_pkg::*;
#(
    parameter int NUM_C1_EDGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic rise_a,
    input  logic rise_b,
    input  logic fall_r,
    input  logic rst_lvl,
    output logic rule_err
);

    localparam int CNT_W = $clog2(NUM_C1_EDGES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_C1_EDGES - 1);

    rel_state_e       st;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        rule_err = ((st == RR_COUNT) && rst_lvl) ||
                   ((st == RR_WAIT_B) && rise_b && !rst_lvl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= RR_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                RR_IDLE: begin
                    if (fall_r) begin
                        st  <= RR_COUNT;
                        cnt <= '0;
                    end
                end
                RR_COUNT: begin
                    if (rst_lvl) begin
                        st <= RR_IDLE;
                    end else if (rise_a) begin
                        if (cnt == LAST) begin
                            st  <= RR_WAIT_B;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                RR_WAIT_B: begin
                    if (rise_b) st <= RR_IDLE;
                end
                default: st <= RR_IDLE;
            endcase
        end
    end

    // R6
    edge_count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R6
    idle_no_rule_err_chk: assert property (@(posedge clk) disable iff (rst)
        (st == RR_IDLE) |-> !rule_err);

endmodule

// File: rtl/error_collector.sv
module error_collector
    import phase_mon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [ERR_W-1:0] fresh,
    output logic             err_sticky,
    output logic [ERR_W-1:0] err_code,
    output logic             viol_pulse
);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_code   <= '0;
            err_sticky <= 1'b0;
            viol_pulse <= 1'b0;
        end else begin
            err_code   <= (clr ? '0 : err_code) | fresh;
            err_sticky <= (clr ? 1'b0 : err_sticky) | (|fresh);
            viol_pulse <= |fresh;
        end
    end

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (err_sticky && !clr) |=> err_sticky);

    // R9
    flag_matches_code_chk: assert property (@(posedge clk) disable iff (rst)
        err_sticky == (err_code != '0));

    // R8
    pulse_implies_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        viol_pulse |-> err_sticky);

endmodule

// File: rtl/phase_seq_monitor.sv
module phase_seq_monitor
    import phase_mon_pkg::*;
#(
    parameter int NUM_C1_EDGES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ph_a,
    input  logic             ph_b,
    input  logic             sys_rst,
    output logic             err_sticky,
    output logic [ERR_W-1:0] err_code,
    output logic             viol_pulse
);

    logic prev_a, prev_b, prev_r;
    logic rise_a, rise_b, fall_r;
    logic ovl_err, ord_err, rule_err;
    logic [ERR_W-1:0] fresh;
    sample_kind_e kind;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_a <= 1'b0;
            prev_b <= 1'b0;
            prev_r <= 1'b0;
        end else begin
            prev_a <= ph_a;
            prev_b <= ph_b;
            prev_r <= sys_rst;
        end
    end

    always_comb begin
        kind   = classify(ph_a, ph_b);
        rise_a = ph_a & ~prev_a;
        rise_b = ph_b & ~prev_b;
        fall_r = prev_r & ~sys_rst;
        fresh          = '0;
        fresh[ERR_OVL] = ovl_err;
        fresh[ERR_ORD] = ord_err;
        fresh[ERR_RST] = rule_err;
    end

    phase_order_fsm u_order (
        .clk     (clk),
        .rst     (rst),
        .kind    (kind),
        .ovl_err (ovl_err),
        .ord_err (ord_err)
    );

    reset_rule_tracker #(.NUM_C1_EDGES(NUM_C1_EDGES)) u_rel (
        .clk      (clk),
        .rst      (rst),
        .rise_a   (rise_a),
        .rise_b   (rise_b),
        .fall_r   (fall_r),
        .rst_lvl  (sys_rst),
        .rule_err (rule_err)
    );

    error_collector u_err (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .fresh      (fresh),
        .err_sticky (err_sticky),
        .err_code   (err_code),
        .viol_pulse (viol_pulse)
    );

    // R1
    overlap_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_a && ph_b) |=> (viol_pulse && err_code[ERR_OVL]));

    // R10
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!err_sticky && !viol_pulse && (err_code == '0)));

endmodule

// File: tb/phase_seq_monitor_test.sv
module phase_seq_monitor_test;

    logic clk = 1'b0;
    logic rst, clr, ph_a, ph_b, sys_rst;
    logic err_sticky, viol_pulse;
    logic [2:0] err_code;
    int checks = 0;
    int fails  = 0;

    localparam logic [2:0] C_NONE = 3'b000;
    localparam logic [2:0] C_OVL  = 3'b001;
    localparam logic [2:0] C_ORD  = 3'b010;
    localparam logic [2:0] C_RST  = 3'b100;

    always #5 clk = ~clk;

    phase_seq_monitor #(.NUM_C1_EDGES(3)) uut (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .ph_a       (ph_a),
        .ph_b       (ph_b),
        .sys_rst    (sys_rst),
        .err_sticky (err_sticky),
        .err_code   (err_code),
        .viol_pulse (viol_pulse)
    );

    function automatic logic [2:0] merge(input logic [2:0] old, input logic clr_now,
                                         input logic [2:0] fresh);
        return (clr_now ? 3'b000 : old) | fresh;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic smp(input logic a, input logic b, input logic r);
        ph_a = a; ph_b = b; sys_rst = r;
        @(posedge clk);
        #1;
    endtask

    task automatic do_rst;
        rst = 1'b1; clr = 1'b0; ph_a = 1'b0; ph_b = 1'b0; sys_rst = 1'b0;
        @(posedge clk); @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    task automatic legal_cycle(input logic r);
        int n;
        n = int'($urandom_range(3, 1));
        repeat (n) begin smp(1'b1, 1'b0, r); chk("R3 pulse in A run", viol_pulse, 0); end
        n = int'($urandom_range(2, 0));
        repeat (n) begin smp(1'b0, 1'b0, r); chk("R3 pulse in gap", viol_pulse, 0); end
        n = int'($urandom_range(3, 1));
        repeat (n) begin smp(1'b0, 1'b1, r); chk("R3 pulse in B run", viol_pulse, 0); end
        n = int'($urandom_range(2, 0));
        repeat (n) begin smp(1'b0, 1'b0, r); chk("R3 pulse in gap", viol_pulse, 0); end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R10 watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; clr = 1'b0; ph_a = 1'b0; ph_b = 1'b0; sys_rst = 1'b0;
        @(posedge clk); #1;
        // R10 reset state
        chk("R10 sticky at reset", err_sticky, 0);
        chk("R10 code at reset", err_code, C_NONE);
        chk("R10 pulse at reset", viol_pulse, 0);

        // R3 random legal loops
        do_rst;
        for (int i = 0; i < 40; i++) legal_cycle(1'b0);
        chk("R3 code after legal loops", err_code, C_NONE);
        chk("R3 sticky after legal loops", err_sticky, 0);

        // R1 overlap while unsynchronised
        do_rst;
        smp(1'b1, 1'b1, 1'b0);
        chk("R1 overlap code", err_code, C_OVL);
        chk("R8 overlap pulse", viol_pulse, 1);
        smp(1'b0, 1'b0, 1'b0);
        chk("R8 pulse drops after clean sample", viol_pulse, 0);
        chk("R9 sticky held", err_sticky, 1);
        // R1 overlap while armed, then tracker back to unsynchronised
        do_rst;
        smp(1'b1, 1'b0, 1'b0);
        smp(1'b1, 1'b1, 1'b0);
        chk("R1 armed overlap code", err_code, C_OVL);
        smp(1'b0, 1'b0, 1'b0);
        smp(1'b0, 1'b1, 1'b0);
        chk("R1 re-unsynced no order error", err_code, C_OVL);

        // R2 B pulses before arming
        do_rst;
        smp(1'b0, 1'b1, 1'b0);
        smp(1'b0, 1'b0, 1'b0);
        smp(1'b0, 1'b1, 1'b0);
        chk("R2 unarmed code", err_code, C_NONE);
        chk("R2 unarmed pulse", viol_pulse, 0);

        // R4 A again after gap, no B region
        do_rst;
        smp(1'b1, 1'b0, 1'b0);
        smp(1'b0, 1'b0, 1'b0);
        smp(1'b1, 1'b0, 1'b0);
        chk("R4 order code", err_code, C_ORD);
        chk("R4 pulse", viol_pulse, 1);

        // R5 B again after gap, no A region
        do_rst;
        smp(1'b1, 1'b0, 1'b0);
        smp(1'b0, 1'b1, 1'b0);
        smp(1'b0, 1'b0, 1'b0);
        chk("R5 no error before second B", err_code, C_NONE);
        smp(1'b0, 1'b1, 1'b0);
        chk("R5 order code", err_code, C_ORD);
        chk("R5 pulse", viol_pulse, 1);

        // R9 clear with clean sample, then clear colliding with new violation
        clr = 1'b1;
        smp(1'b0, 1'b1, 1'b0);
        clr = 1'b0;
        chk("R9 clear code", err_code, C_NONE);
        chk("R9 clear sticky", err_sticky, 0);
        smp(1'b0, 1'b0, 1'b0);
        smp(1'b0, 1'b1, 1'b0);
        chk("R5 repeated order code", err_code, C_ORD);
        clr = 1'b1;
        smp(1'b1, 1'b1, 1'b0);
        clr = 1'b0;
        chk("R9 clear vs new violation", err_code, merge(C_ORD, 1'b1, C_OVL));
        chk("R9 sticky stays on new violation", err_sticky, 1);

        // R6 reset reasserted after only one A rise
        do_rst;
        smp(1'b1, 1'b0, 1'b1);
        smp(1'b0, 1'b0, 1'b1);
        smp(1'b0, 1'b0, 1'b0);
        smp(1'b0, 1'b1, 1'b0);
        smp(1'b0, 1'b0, 1'b0);
        smp(1'b1, 1'b0, 1'b0);
        chk("R6 no error while counting", err_code, C_NONE);
        smp(1'b0, 1'b0, 1'b1);
        chk("R6 short release code", err_code, C_RST);
        chk("R6 short release pulse", viol_pulse, 1);

        // R7 proper release: high at next B rise
        do_rst;
        sys_rst = 1'b1;
        legal_cycle(1'b1);
        smp(1'b0, 1'b0, 1'b0);
        legal_cycle(1'b0);
        legal_cycle(1'b0);
        smp(1'b1, 1'b0, 1'b0);
        smp(1'b0, 1'b0, 1'b0);
        smp(1'b0, 1'b1, 1'b1);
        chk("R7 good release code", err_code, C_NONE);
        chk("R7 good release pulse", viol_pulse, 0);

        // R7 bad release: low at next B rise
        do_rst;
        sys_rst = 1'b1;
        legal_cycle(1'b1);
        smp(1'b0, 1'b0, 1'b0);
        legal_cycle(1'b0);
        legal_cycle(1'b0);
        smp(1'b1, 1'b0, 1'b0);
        smp(1'b0, 1'b0, 1'b0);
        smp(1'b0, 1'b1, 1'b0);
        chk("R7 low at B rise code", err_code, C_RST);
        chk("R7 low at B rise pulse", viol_pulse, 1);

        // R10 checker reset clears error and unarms tracker
        rst = 1'b1;
        smp(1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        chk("R10 reset clears code", err_code, C_NONE);
        smp(1'b0, 1'b1, 1'b0);
        smp(1'b0, 1'b0, 1'b0);
        smp(1'b0, 1'b1, 1'b0);
        chk("R10 unsynced after reset", err_code, C_NONE);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule